// File: doc/BRIEF.md
# Two-Level Local Branch Predictor

This block predicts, within the fetch cycle, whether a branch at the current fetch address will be taken and where it goes. A direct-mapped target buffer holds a tag, a target and a short private outcome history for each tracked branch. The history of the matching entry, joined with the entry index, selects one 2-bit saturating counter in a pattern table. The upper bit of that counter gives the direction.

The execute stage sends one resolution per cycle. A resolution carries the branch address, the real outcome, the real target and a flag that says the earlier prediction was wrong. A resolution that hits the buffer trains the entry. A taken branch that misses claims an entry and replaces whatever branch was there. Flushing the pipeline is done elsewhere.

Top module: `branch_pred_local`

## Requirements
- R1: After synchronous reset, every lookup misses: `pred_hit`=0, `pred_taken`=0 and `pred_target`=0, and every pattern counter holds 1 (weakly not taken).
- R2: A lookup uses index = PC bits [7:1] and tag = PC bits [31:8]. It hits only when that entry is valid and its stored tag equals the tag. On a miss, `pred_taken` and `pred_target` are 0. A valid entry with a different tag also gives a miss.
- R3: A resolution with taken=1 that misses claims the entry. It sets the entry valid, writes the tag and target, clears the entry history to 000, and increments the counter at (index, 000).
- R4: A resolution with taken=0 that misses changes nothing. A branch already in that slot keeps hitting with the same prediction and target.
- R5: On a hit, `pred_taken` is bit 1 of the counter at address index*8 + history, and `pred_target` is the stored target.
- R6: A resolution that hits shifts the entry history left by one and puts the outcome in bit 0. It also trains the counter selected by the history held before the shift.
- R7: Counters count up on taken and down on not taken, saturating at 3 and at 0.
- R8: On a hit, the stored target is rewritten only when taken=1 and mispredict=1. Otherwise it is kept.
- R9: A lookup and a resolution in the same cycle return the state from before that resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address looked up this cycle |
| pred_hit | output | 1 | A valid entry matches `fetch_pc` |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | PC_W | Predicted target, 0 on a miss |
| upd_valid | input | 1 | A resolution is present |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome |
| upd_target | input | PC_W | Real target |
| upd_mispredict | input | 1 | The earlier prediction was wrong |

## Verification
The bench builds the block with its default sizes: 32-bit addresses, 128 entries, 3-bit histories and 1024 counters. Random addresses are drawn from four indices, each paired with three tags. This makes alias replacement, aliased not-taken misses and long runs on a single history common. Those runs push counters into both saturation limits. Directed steps cover lookups just after reset, a claim of an entry in the same cycle as a lookup of it, and target refresh with and without the mispredict flag.

// File: rtl/bp_pkg.sv
package bp_pkg;
  parameter int unsigned CNT_W = 2;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX = '1;
  localparam cnt_t CNT_RST = cnt_t'(1);

  function automatic cnt_t cnt_step(input cnt_t c, input logic up);
    if (up) return (c == CNT_MAX) ? c : c + cnt_t'(1);
    else    return (c == '0) ? c : c - cnt_t'(1);
  endfunction
endpackage

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned HIST_W = 3,
  localparam int unsigned TAG_W = PC_W - IDX_W - 1,
  localparam int unsigned ENT   = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [PC_W-1:0]   rd_target,
  output logic [HIST_W-1:0] rd_hist,
  input  logic [IDX_W-1:0]  up_idx,
  input  logic [TAG_W-1:0]  up_tag,
  output logic              up_hit,
  output logic [HIST_W-1:0] up_hist,
  input  logic              we_alloc,
  input  logic              we_train,
  input  logic              we_target,
  input  logic              up_taken,
  input  logic [PC_W-1:0]   up_target
);
  logic [ENT-1:0]    vld_q;
  logic [TAG_W-1:0]  tag_mem  [ENT];
  logic [PC_W-1:0]   tgt_mem  [ENT];
  logic [HIST_W-1:0] hist_mem [ENT];
  logic [PC_W-1:0]   up_tgt_old;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (we_alloc) vld_q[up_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we_alloc)  tag_mem[up_idx] <= up_tag;
    if (we_target) tgt_mem[up_idx] <= up_target;
    if (we_alloc)      hist_mem[up_idx] <= '0;
    else if (we_train) hist_mem[up_idx] <= {hist_mem[up_idx][HIST_W-2:0], up_taken};
  end

  assign rd_hit     = vld_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
  assign rd_target  = tgt_mem[rd_idx];
  assign rd_hist    = hist_mem[rd_idx];
  assign up_hit     = vld_q[up_idx] && (tag_mem[up_idx] == up_tag);
  assign up_hist    = hist_mem[up_idx];
  assign up_tgt_old = tgt_mem[up_idx];

  assert_alloc_valid_R3: assert property (@(posedge clk) disable iff (rst)
    we_alloc |=> vld_q[$past(up_idx)] && hist_mem[$past(up_idx)] == '0);
  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !we_alloc |=> $stable(vld_q));
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (rst)
    (we_train && !we_alloc) |=>
      hist_mem[$past(up_idx)] == {$past(up_hist[HIST_W-2:0]), $past(up_taken)});
  assert_tgt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (we_train && !we_target) |=> tgt_mem[$past(up_idx)] == $past(up_tgt_old));
endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int unsigned AW = 10,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_taken,
  input  logic          up_we,
  input  logic [AW-1:0] up_addr,
  input  logic          up_taken
);
  cnt_t cnt_q [DEPTH];
  cnt_t old_cnt;

  assign old_cnt  = cnt_q[up_addr];
  assign rd_taken = cnt_q[rd_addr][CNT_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) cnt_q[k] <= CNT_RST;
    end else if (up_we) begin
      cnt_q[up_addr] <= cnt_step(old_cnt, up_taken);
    end
  end

  assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
    (up_we && up_taken && old_cnt == CNT_MAX) |=> cnt_q[$past(up_addr)] == CNT_MAX);
  assert_sat_low_R7: assert property (@(posedge clk) disable iff (rst)
    (up_we && !up_taken && old_cnt == '0) |=> cnt_q[$past(up_addr)] == '0);
  assert_count_up_R7: assert property (@(posedge clk) disable iff (rst)
    (up_we && up_taken && old_cnt != CNT_MAX) |=>
      cnt_q[$past(up_addr)] == cnt_t'($past(old_cnt) + cnt_t'(1)));
endmodule

// File: rtl/branch_pred_local.sv
module branch_pred_local #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned HIST_W = 3,
  localparam int unsigned TAG_W = PC_W - IDX_W - 1,
  localparam int unsigned PHT_AW = IDX_W + HIST_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_mispredict
);
  logic [IDX_W-1:0]  f_idx, u_idx;
  logic [TAG_W-1:0]  f_tag, u_tag;
  logic              f_hit, u_hit, f_dir;
  logic [PC_W-1:0]   f_tgt;
  logic [HIST_W-1:0] f_hist, u_hist;
  logic              alloc, train, tgt_we;
  logic              unused_pc_lsb;

  assign f_idx = fetch_pc[IDX_W:1];
  assign f_tag = fetch_pc[PC_W-1:IDX_W+1];
  assign u_idx = upd_pc[IDX_W:1];
  assign u_tag = upd_pc[PC_W-1:IDX_W+1];
  assign unused_pc_lsb = fetch_pc[0] ^ upd_pc[0];

  assign alloc  = upd_valid && upd_taken && !u_hit;
  assign train  = upd_valid && u_hit;
  assign tgt_we = alloc || (train && upd_taken && upd_mispredict);

  bp_btb #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) i_btb (
    .clk(clk), .rst(rst),
    .rd_idx(f_idx), .rd_tag(f_tag), .rd_hit(f_hit), .rd_target(f_tgt), .rd_hist(f_hist),
    .up_idx(u_idx), .up_tag(u_tag), .up_hit(u_hit), .up_hist(u_hist),
    .we_alloc(alloc), .we_train(train), .we_target(tgt_we),
    .up_taken(upd_taken), .up_target(upd_target)
  );

  bp_pht #(.AW(PHT_AW)) i_pht (
    .clk(clk), .rst(rst),
    .rd_addr({f_idx, f_hist}), .rd_taken(f_dir),
    .up_we(alloc || train),
    .up_addr({u_idx, alloc ? {HIST_W{1'b0}} : u_hist}),
    .up_taken(upd_taken)
  );

  assign pred_hit    = f_hit;
  assign pred_taken  = f_hit && f_dir;
  assign pred_target = f_hit ? f_tgt : '0;

  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (!pred_taken && pred_target == '0));
endmodule

// File: tb/test_branch_pred_local.sv
`timescale 1ns/1ps
module test_branch_pred_local;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0, upd_pc = '0, upd_target = '0;
  logic        upd_valid = 1'b0, upd_taken = 1'b0, upd_mispredict = 1'b0;
  logic        pred_hit, pred_taken;
  logic [31:0] pred_target;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  bit          ref_vld [128];
  logic [23:0] ref_tag [128];
  logic [31:0] ref_tgt [128];
  int          ref_hist[128];
  int          ref_pht [1024];

  always #10 clk = ~clk;

  branch_pred_local i_branch_pred_local (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_mispredict(upd_mispredict)
  );

  function automatic int sat(input int c, input bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic logic [31:0] mkpc(input int tag, input int idx);
    return {tag[23:0], idx[6:0], 1'b0};
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] fpc, input bit uv, input logic [31:0] upc,
                      input bit ut, input logic [31:0] utg, input bit um, input string rq);
    int i, ui, a;
    bit eh, et, uh;
    logic [31:0] etg;
    @(negedge clk);
    fetch_pc = fpc; upd_valid = uv; upd_pc = upc;
    upd_taken = ut; upd_target = utg; upd_mispredict = um;
    #2;
    i  = int'(fpc[7:1]);
    eh = ref_vld[i] && (ref_tag[i] == fpc[31:8]);
    et = eh && (ref_pht[i*8 + ref_hist[i]] >= 2);
    etg = eh ? ref_tgt[i] : 32'h0;
    chk(rq, "hit", {31'h0, pred_hit}, {31'h0, eh});
    chk(rq, "taken", {31'h0, pred_taken}, {31'h0, et});
    chk(rq, "target", pred_target, etg);
    @(posedge clk);
    ui = int'(upc[7:1]);
    uh = ref_vld[ui] && (ref_tag[ui] == upc[31:8]);
    if (uv) begin
      if (uh) begin
        a = ui*8 + ref_hist[ui];
        ref_pht[a] = sat(ref_pht[a], ut);
        ref_hist[ui] = ((ref_hist[ui] << 1) | int'(ut)) & 7;
        if (ut && um) ref_tgt[ui] = utg;
      end else if (ut) begin
        ref_vld[ui] = 1'b1; ref_tag[ui] = upc[31:8]; ref_tgt[ui] = utg;
        ref_hist[ui] = 0;
        ref_pht[ui*8] = sat(ref_pht[ui*8], 1'b1);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa, pb, pc_alias;
    void'($urandom(32'd4711));
    for (int k = 0; k < 128; k++) begin ref_vld[k] = 0; ref_tag[k] = '0; ref_tgt[k] = '0; ref_hist[k] = 0; end
    for (int k = 0; k < 1024; k++) ref_pht[k] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    pa = mkpc(24'h000123, 5);
    pb = mkpc(24'h000456, 9);
    pc_alias = mkpc(24'h000777, 5);

    // R1: reset state, nothing hits
    step(pa, 0, pa, 0, 0, 0, "R1");
    step(pb, 0, pb, 0, 0, 0, "R1");
    // R4: not-taken miss leaves the slot empty
    step(pa, 1, pa, 0, 32'h1000, 1, "R4");
    step(pa, 0, pa, 0, 0, 0, "R4");
    // R3: taken miss claims the entry, counter 1->2 predicts taken
    step(pa, 1, pa, 1, 32'h2000, 1, "R3");
    step(pa, 0, pa, 0, 0, 0, "R3");
    // R9: lookup of an entry claimed in the same cycle still misses
    step(pb, 1, pb, 1, 32'h3000, 1, "R9");
    step(pb, 0, pb, 0, 0, 0, "R9");
    // R2: alias with other tag misses; R4: aliased not-taken keeps the old entry
    step(pc_alias, 1, pc_alias, 0, 32'h4000, 1, "R2");
    step(pa, 0, pa, 0, 0, 0, "R4");
    // R8: hit, taken, no mispredict keeps target; with mispredict rewrites it
    step(pa, 1, pa, 1, 32'h5000, 0, "R8");
    step(pa, 0, pa, 0, 0, 0, "R8");
    step(pa, 1, pa, 1, 32'h6000, 1, "R8");
    step(pa, 0, pa, 0, 0, 0, "R8");
    // R6/R7: long taken run saturates counter at history 111, then not taken
    for (int k = 0; k < 8; k++) step(pa, 1, pa, 1, 32'h6000, 0, "R7");
    step(pa, 1, pa, 0, 32'h6000, 0, "R6");
    for (int k = 0; k < 3; k++) step(pa, 1, pa, 1, 32'h6000, 0, "R7");
    for (int k = 0; k < 8; k++) step(pa, 1, pa, 0, 32'h6000, 0, "R7");
    step(pa, 0, pa, 0, 0, 0, "R5");
    // R2: taken alias replaces the old branch
    step(pa, 1, pc_alias, 1, 32'h7000, 1, "R2");
    step(pa, 0, pa, 0, 0, 0, "R2");
    step(pc_alias, 0, pa, 0, 0, 0, "R2");

    // random phase, R5/R6 with aliasing pool
    for (int n = 0; n < 4000; n++) begin
      int fi, ft, ui, ut;
      fi = 16 + int'($urandom % 4); ft = 1 + int'($urandom % 3);
      ui = 16 + int'($urandom % 4); ut = 1 + int'($urandom % 3);
      step(mkpc(ft, fi), ($urandom % 10) < 7, mkpc(ut, ui), ($urandom % 10) < 6,
           $urandom, $urandom % 2, "R6");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule